// File: doc/BRIEF.md
# Processor Clock, Reset and Ready Generator

This block takes one fast oscillator clock and derives from it every timing signal a small processor needs. A three-phase state machine divides the oscillator by three and drives the processor clock high for one oscillator period out of every three. A toggle flop flips on each falling edge of the processor clock, which gives a peripheral clock at half the processor rate with an even duty cycle.

The block also provides a shared active-high RESET and a qualified READY. An asynchronous active-low request forces RESET on at once. RESET is released only after two processor-clock rising edges have passed. Each of the two device ready inputs counts only while its enable is high. The OR of the qualified inputs passes through a two-stage chain that advances on processor-clock rising edges, so slow devices can stretch bus cycles without presenting a metastable input.

The whole block runs on the oscillator clock. Processor-clock edges appear internally as one-cycle enables. The phase machine has three states: HI (processor clock high), LO_A and LO_B (processor clock low). It always steps HI to LO_A, LO_A to LO_B, and LO_B to HI. The request forces it into HI.

Top module: `osc_clock_reset_unit`

## Requirements
- R1: `cpu_clk_o` has a period of 3 oscillator cycles and is high for exactly 1 of them.
- R2: `per_clk_o` changes exactly on the oscillator edges where `cpu_clk_o` falls. Its period is 6 oscillator cycles, high for 3 of them.
- R3: While `rst_req_n_i` is low, the phase machine is held in HI, so `cpu_clk_o` is 1 and `per_clk_o` is 0. After release, `cpu_clk_o` is 0 after the 1st and 2nd oscillator edges and 1 after the 3rd. `per_clk_o` becomes 1 after the 1st edge.
- R4: `reset_o` goes to 1 as soon as `rst_req_n_i` goes low, with no oscillator edge needed.
- R5: `reset_o` goes to 0 on the second rising edge of `cpu_clk_o` after release, which is the 6th oscillator edge. It changes on no other kind of edge.
- R6: The raw ready term is (`rdy_a_i` AND `rdy_a_en_i`) OR (`rdy_b_i` AND `rdy_b_en_i`). An input whose enable is 0 has no effect on `ready_o`.
- R7: A change of the raw ready term reaches `ready_o` on the second `cpu_clk_o` rising edge after it. `ready_o` changes only on `cpu_clk_o` rising edges, apart from reset.
- R8: `ready_o` is 0 whenever `rst_req_n_i` is low, whatever the ready inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk_i | input | 1 | Fast oscillator clock |
| rst_req_n_i | input | 1 | Asynchronous reset request, active low |
| rdy_a_i | input | 1 | Ready from device A |
| rdy_a_en_i | input | 1 | Qualifier for device A ready |
| rdy_b_i | input | 1 | Ready from device B |
| rdy_b_en_i | input | 1 | Qualifier for device B ready |
| cpu_clk_o | output | 1 | Processor clock, oscillator divided by 3, one-third duty |
| per_clk_o | output | 1 | Peripheral clock, half of processor rate, even duty |
| reset_o | output | 1 | Synchronized reset, active high |
| ready_o | output | 1 | Synchronized combined ready |

## Verification
The reset release and the ready capture share one processor-clock rising edge. If a qualified ready input is held high through the reset request, RESET must fall and READY must rise after the same oscillator edge, the sixth after release. The bench provokes this by enabling device A before release and sampling both outputs after edges five and six. It judges the pair against the edge count it keeps itself. A second overlap is the asynchronous request arriving between oscillator edges while READY is high. Both outputs are then checked before any further edge.

// File: rtl/clkrst_pkg.sv
package clkrst_pkg;
    // one-hot phase encoding: bit 0 is the processor clock level
    typedef enum logic [2:0] {
        PH_HI   = 3'b001,
        PH_LO_A = 3'b010,
        PH_LO_B = 3'b100
    } div_phase_e;
endpackage

// File: rtl/div3_phase_fsm.sv
module div3_phase_fsm
    import clkrst_pkg::*;
(
    input  logic osc_clk_i,
    input  logic rst_n_i,
    output logic cpu_clk_o,
    output logic rise_en_o,
    output logic fall_en_o
);
    div_phase_e state_q, state_d;

    // state register
    always_ff @(posedge osc_clk_i or negedge rst_n_i) begin
        if (!rst_n_i) state_q <= PH_HI;
        else          state_q <= state_d;
    end

    // transitions: HI -> LO_A -> LO_B -> HI
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_HI:   state_d = PH_LO_A;
            PH_LO_A: state_d = PH_LO_B;
            PH_LO_B: state_d = PH_HI;
            default: state_d = PH_HI;
        endcase
    end

    // outputs: clock straight from a flop bit, edge enables from phase
    always_comb begin
        cpu_clk_o = state_q[0];
        rise_en_o = (state_q == PH_LO_B);
        fall_en_o = (state_q == PH_HI);
    end
endmodule

// File: rtl/half_rate_toggle.sv
module half_rate_toggle (
    input  logic osc_clk_i,
    input  logic rst_n_i,
    input  logic flip_en_i,
    output logic tog_o
);
    logic tog_q;

    always_ff @(posedge osc_clk_i or negedge rst_n_i) begin
        if (!rst_n_i)       tog_q <= 1'b0;
        else if (flip_en_i) tog_q <= ~tog_q;
    end

    assign tog_o = tog_q;
endmodule

// File: rtl/edge_en_sync.sv
module edge_en_sync #(
    parameter int STAGES = 2
) (
    input  logic osc_clk_i,
    input  logic rst_n_i,
    input  logic adv_en_i,
    input  logic d_i,
    output logic q_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge osc_clk_i or negedge rst_n_i) begin
                if (!rst_n_i)      chain_q[g] <= 1'b0;
                else if (adv_en_i) chain_q[g] <= (g == 0) ? d_i : chain_q[(g == 0) ? 0 : g - 1];
            end
        end
    endgenerate

    assign q_o = chain_q[LAST];
endmodule

// File: rtl/osc_clock_reset_unit.sv
module osc_clock_reset_unit #(
    parameter int SYNC_STAGES = 2
) (
    input  logic osc_clk_i,
    input  logic rst_req_n_i,
    input  logic rdy_a_i,
    input  logic rdy_a_en_i,
    input  logic rdy_b_i,
    input  logic rdy_b_en_i,
    output logic cpu_clk_o,
    output logic per_clk_o,
    output logic reset_o,
    output logic ready_o
);
    logic rise_en, fall_en;
    logic rst_clear, rdy_raw;

    div3_phase_fsm u_div (
        .osc_clk_i (osc_clk_i),
        .rst_n_i   (rst_req_n_i),
        .cpu_clk_o (cpu_clk_o),
        .rise_en_o (rise_en),
        .fall_en_o (fall_en)
    );

    half_rate_toggle u_per (
        .osc_clk_i (osc_clk_i),
        .rst_n_i   (rst_req_n_i),
        .flip_en_i (fall_en),
        .tog_o     (per_clk_o)
    );

    // reset release walks a constant one through the chain
    edge_en_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
        .osc_clk_i (osc_clk_i),
        .rst_n_i   (rst_req_n_i),
        .adv_en_i  (rise_en),
        .d_i       (1'b1),
        .q_o       (rst_clear)
    );
    assign reset_o = ~rst_clear;

    assign rdy_raw = (rdy_a_i & rdy_a_en_i) | (rdy_b_i & rdy_b_en_i);

    edge_en_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
        .osc_clk_i (osc_clk_i),
        .rst_n_i   (rst_req_n_i),
        .adv_en_i  (rise_en),
        .d_i       (rdy_raw),
        .q_o       (ready_o)
    );
endmodule

// File: rtl/clkrst_checker.sv
module clkrst_checker (
    input logic osc_clk_i,
    input logic rst_req_n_i,
    input logic cpu_clk_o,
    input logic per_clk_o,
    input logic reset_o,
    input logic ready_o
);
    // R1
    cpu_hi_one_chk: assert property (@(posedge osc_clk_i) disable iff (!rst_req_n_i)
        cpu_clk_o |=> !cpu_clk_o);
    // R1
    cpu_lo_two_chk: assert property (@(posedge osc_clk_i) disable iff (!rst_req_n_i)
        $fell(cpu_clk_o) |=> !cpu_clk_o);
    // R1
    cpu_back_hi_chk: assert property (@(posedge osc_clk_i) disable iff (!rst_req_n_i)
        (!cpu_clk_o && !$past(cpu_clk_o)) |=> cpu_clk_o);
    // R2
    per_on_fall_chk: assert property (@(posedge osc_clk_i) disable iff (!rst_req_n_i)
        !$stable(per_clk_o) |-> $fell(cpu_clk_o));
    // R2
    fall_flips_per_chk: assert property (@(posedge osc_clk_i) disable iff (!rst_req_n_i)
        $fell(cpu_clk_o) |-> !$stable(per_clk_o));
    // R5
    reset_rel_rise_chk: assert property (@(posedge osc_clk_i) disable iff (!rst_req_n_i)
        $fell(reset_o) |-> $rose(cpu_clk_o));
    // R7
    ready_on_rise_chk: assert property (@(posedge osc_clk_i) disable iff (!rst_req_n_i)
        !$stable(ready_o) |-> $rose(cpu_clk_o));
    // R4 R8
    req_forces_chk: assert property (@(posedge osc_clk_i)
        !rst_req_n_i |-> (reset_o && !ready_o));
endmodule

bind osc_clock_reset_unit clkrst_checker chk_i (
    .osc_clk_i   (osc_clk_i),
    .rst_req_n_i (rst_req_n_i),
    .cpu_clk_o   (cpu_clk_o),
    .per_clk_o   (per_clk_o),
    .reset_o     (reset_o),
    .ready_o     (ready_o)
);

// File: tb/osc_clock_reset_unit_tb_top.sv
module osc_clock_reset_unit_tb_top;
    logic osc_clk = 1'b0;
    logic rst_req_n = 1'b0;
    logic rdy_a = 1'b0, rdy_a_en = 1'b0, rdy_b = 1'b0, rdy_b_en = 1'b0;
    logic cpu_clk, per_clk, reset_w, ready_w;

    int n_run = 0;
    int n_fail = 0;
    int edge_n = 0;
    bit done = 1'b0;

    always #4 osc_clk = ~osc_clk;

    osc_clock_reset_unit dut_i (
        .osc_clk_i   (osc_clk),
        .rst_req_n_i (rst_req_n),
        .rdy_a_i     (rdy_a),
        .rdy_a_en_i  (rdy_a_en),
        .rdy_b_i     (rdy_b),
        .rdy_b_en_i  (rdy_b_en),
        .cpu_clk_o   (cpu_clk),
        .per_clk_o   (per_clk),
        .reset_o     (reset_w),
        .ready_o     (ready_w)
    );

    // {a, a_en, b, b_en, expected ready}
    localparam logic [4:0] VEC [8] = '{
        5'b10000, 5'b01010, 5'b00111, 5'b11001,
        5'b00100, 5'b11111, 5'b10100, 5'b01111
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at edge %0d: actual %b expected %b", req, edge_n, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge osc_clk);
        @(negedge osc_clk);
        edge_n++;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic prev_exp;
        // reset state during request, clock running
        repeat (3) @(negedge osc_clk);
        check("R3 cpu held high", cpu_clk, 1'b1);
        check("R3 per low", per_clk, 1'b0);
        check("R4 reset on", reset_w, 1'b1);
        // qualified ready held through reset (R8: must stay low)
        rdy_a = 1'b1; rdy_a_en = 1'b1;
        @(negedge osc_clk);
        check("R8 ready low in reset", ready_w, 1'b0);
        rst_req_n = 1'b1;
        edge_n = 0;

        // clocks, reset release and ready capture after release
        for (int k = 1; k <= 36; k++) begin
            tick();
            check("R1 R3 cpu_clk phase", cpu_clk, (edge_n % 3) == 0);
            check("R2 per_clk", per_clk, (((edge_n - 1) / 3) % 2) == 0);
            if (edge_n <= 7) begin
                check("R5 reset release", reset_w, edge_n < 6);
                check("R7 ready with reset", ready_w, edge_n >= 6);
            end
        end

        // vector table: edge_n is a multiple of 3, just past a rise
        prev_exp = 1'b1;
        for (int v = 0; v < 8; v++) begin
            {rdy_a, rdy_a_en, rdy_b, rdy_b_en} = VEC[v][4:1];
            repeat (3) tick();
            check("R7 ready after one rise", ready_w, prev_exp);
            repeat (3) tick();
            check("R6 ready combine", ready_w, VEC[v][0]);
            prev_exp = VEC[v][0];
        end

        // asynchronous request between edges while ready is high
        {rdy_a, rdy_a_en, rdy_b, rdy_b_en} = 4'b1111;
        repeat (6) tick();
        check("R6 ready high before request", ready_w, 1'b1);
        #1 rst_req_n = 1'b0;
        #1;
        check("R4 async reset", reset_w, 1'b1);
        check("R8 async ready clear", ready_w, 1'b0);
        check("R3 phase forced high", cpu_clk, 1'b1);
        check("R3 per forced low", per_clk, 1'b0);
        repeat (3) tick();
        check("R8 ready stays low", ready_w, 1'b0);
        check("R3 cpu held", cpu_clk, 1'b1);
        rst_req_n = 1'b1;
        edge_n = 0;
        for (int k = 1; k <= 6; k++) begin
            tick();
            check("R3 restart phase", cpu_clk, (edge_n % 3) == 0);
            check("R5 second release", reset_w, edge_n < 6);
        end
        finish_run();
    end
endmodule